// File: doc/BRIEF.md
# Serial Slave Configuration Loader

This block is the master side of a serial configuration link to a target programmable device that boots as a serial slave. On a start pulse it drives the target's reset low, selects it through an active-low chip select, and releases reset with the select still low, so that the target enters slave configuration mode. After a wait it streams the bitstream. Bytes arrive on a valid/ready input and leave most significant bit first on a data line, with a clock derived from the system clock.

When the byte flagged as last has been shifted out, the loader keeps clocking with the data line held high. It stops when the target's completion input is seen high between two clock cells. It then gives a fixed number of further clocks that let the target release its I/O, and it reports success. If completion does not come within a programmable number of post-stream clocks, it stops and reports an error instead. The contents of the bitstream are neither stored nor inspected here.

Top module: `slave_cfg_loader`

## Requirements
- R1: Out of reset the loader is idle: `cs_no`=1, `tgt_rst_no`=1, `sclk_o`=0, `ready_o`=0, `busy_o`=0, `done_ok_o`=0, `error_o`=0.
- R2: A start pulse while idle drives `tgt_rst_no` low for exactly `RST_CYC` system cycles. `cs_no` is low during that time and is still low on the cycle when `tgt_rst_no` returns high. Each run produces exactly one reset pulse.
- R3: The first rising edge of `sclk_o` comes no earlier than `WAIT_CYC` cycles after reset is released. `sclk_o` stays low while reset is asserted or the chip select is high.
- R4: Each byte is sent as 8 clock cells, bit 7 first. One bit is valid at each rising edge of `sclk_o`, and `mosi_o` changes only while `sclk_o` is low.
- R5: `ready_o` is high only while busy, while the shifter is empty and while `sclk_o` is low. When valid input is missing, the clock stalls without losing or repeating a bit. `last_i` on an accepted byte marks the end of the stream.
- R6: After the last data bit the loader gives clock cells with `mosi_o`=1 until `tgt_done_i` is sampled high at a cell boundary. If `tgt_done_i` is already high then, no such cell is given.
- R7: Once completion is seen, exactly `TRAIL_CLKS` (default 48) further rising edges are issued. The loader then drops `busy_o`, raises `cs_no` and sets `done_ok_o`.
- R8: If `tgt_done_i` is still low at the boundary after `TIMEOUT_CLKS` post-stream cells, the loader stops with `error_o`=1 and issues no trailing clocks. Completion seen at that same boundary still counts as success.
- R9: A start pulse while `busy_o` is high has no effect on the sequence.
- R10: `done_ok_o` and `error_o` are never high together. They hold until the next accepted start and read 0 while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, honoured only when idle |
| byte_i | input | DATA_W | Bitstream byte |
| valid_i | input | 1 | `byte_i` is valid |
| last_i | input | 1 | Current byte is the final one |
| ready_o | output | 1 | Loader takes the byte this cycle |
| sclk_o | output | 1 | Serial clock to target |
| mosi_o | output | 1 | Serial data to target |
| cs_no | output | 1 | Target chip select, active low |
| tgt_rst_no | output | 1 | Target reset, active low |
| tgt_done_i | input | 1 | Target configuration-complete flag |
| busy_o | output | 1 | Sequence in progress |
| done_ok_o | output | 1 | Last run finished with completion |
| error_o | output | 1 | Last run timed out |

## Verification
The sweep varies the stream length over one to three bytes with changing byte values. It also varies the idle gaps on the valid input, which separates correct stalling from lost or repeated bits. The moment completion rises is swept from the cell of the last data bit through every post-stream count up to the timeout limit, and one run never raises it. This separates zero-fill, normal-fill, limit-boundary and timeout outcomes and checks the 48 trailing edges in each successful case. Some runs add a start pulse during reset or during streaming, to show it causes no second reset pulse.

// File: rtl/slave_cfg_loader_pkg.sv
package slave_cfg_loader_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RESET,
    ST_WAIT,
    ST_STREAM,
    ST_FLUSH,
    ST_TRAIL
  } ld_state_e;
endpackage

// File: rtl/cfg_sclk_gen.sv
module cfg_sclk_gen #(
  parameter int HALF = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic sclk_o,
  output logic cell_end_o
);
  localparam int CELL = 2 * HALF;
  localparam int DW   = (CELL > 2) ? $clog2(CELL) : 1;
  localparam logic [DW-1:0] LAST = DW'(CELL - 1);
  localparam logic [DW-1:0] MID  = DW'(HALF);

  logic [DW-1:0] cnt_q;

  assign cell_end_o = run_i && (cnt_q == LAST);
  assign sclk_o     = run_i && (cnt_q >= MID);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (run_i && !cell_end_o) cnt_q <= cnt_q + 1'b1;
    else                          cnt_q <= '0;
  end
endmodule

// File: rtl/cfg_byte_shifter.sv
module cfg_byte_shifter #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] data_i,
  input  logic         shift_i,
  output logic         bit_o,
  output logic         empty_o
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  sr_q;
  logic [CW-1:0] cnt_q;

  assign bit_o   = sr_q[W-1];
  assign empty_o = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q  <= '1;
      cnt_q <= '0;
    end else if (load_i) begin
      sr_q  <= data_i;
      cnt_q <= CW'(W);
    end else if (shift_i && !empty_o) begin
      sr_q  <= {sr_q[W-2:0], 1'b1};   // fill with ones for post-stream cells
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/slave_cfg_loader.sv
module slave_cfg_loader
  import slave_cfg_loader_pkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int HALF         = 2,
  parameter int RST_CYC      = 16,
  parameter int WAIT_CYC     = 64,
  parameter int TIMEOUT_CLKS = 1000,
  parameter int TRAIL_CLKS   = 48
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DATA_W-1:0] byte_i,
  input  logic              valid_i,
  input  logic              last_i,
  output logic              ready_o,
  output logic              sclk_o,
  output logic              mosi_o,
  output logic              cs_no,
  output logic              tgt_rst_no,
  input  logic              tgt_done_i,
  output logic              busy_o,
  output logic              done_ok_o,
  output logic              error_o
);
  localparam int M1   = (RST_CYC > WAIT_CYC) ? RST_CYC : WAIT_CYC;
  localparam int M2   = (TIMEOUT_CLKS > TRAIL_CLKS) ? TIMEOUT_CLKS : TRAIL_CLKS;
  localparam int MAXV = (M1 > M2) ? M1 : M2;
  localparam int CW   = $clog2(MAXV + 1);
  localparam logic [CW-1:0] RST_LIM  = CW'(RST_CYC - 1);
  localparam logic [CW-1:0] WAIT_LIM = CW'(WAIT_CYC - 1);
  localparam logic [CW-1:0] TO_LIM   = CW'(TIMEOUT_CLKS);
  localparam logic [CW-1:0] TR_LIM   = CW'(TRAIL_CLKS);

  ld_state_e     state_q;
  logic [CW-1:0] tmr_q;
  logic          cell_q, last_q, ok_q, err_q;
  logic          cell_end, empty, load, shift;

  cfg_sclk_gen #(.HALF(HALF)) u_clk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (cell_q),
    .sclk_o    (sclk_o),
    .cell_end_o(cell_end)
  );

  cfg_byte_shifter #(.W(DATA_W)) u_shf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .data_i (byte_i),
    .shift_i(shift),
    .bit_o  (mosi_o),
    .empty_o(empty)
  );

  assign ready_o    = (state_q == ST_STREAM) && empty && !last_q && !cell_q;
  assign load       = valid_i && ready_o;
  assign shift      = cell_end && (state_q == ST_STREAM);
  assign cs_no      = (state_q == ST_IDLE);
  assign tgt_rst_no = (state_q != ST_RESET);
  assign busy_o     = (state_q != ST_IDLE);
  assign done_ok_o  = ok_q;
  assign error_o    = err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      tmr_q   <= '0;
      cell_q  <= 1'b0;
      last_q  <= 1'b0;
      ok_q    <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      if (cell_end) cell_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_RESET;
          tmr_q   <= '0;
          last_q  <= 1'b0;
          ok_q    <= 1'b0;
          err_q   <= 1'b0;
        end
        ST_RESET: begin
          tmr_q <= tmr_q + 1'b1;
          if (tmr_q == RST_LIM) begin
            state_q <= ST_WAIT;
            tmr_q   <= '0;
          end
        end
        ST_WAIT: begin
          tmr_q <= tmr_q + 1'b1;
          if (tmr_q == WAIT_LIM) state_q <= ST_STREAM;
        end
        ST_STREAM: begin
          if (load) last_q <= last_i;
          if (!cell_q && !empty) cell_q <= 1'b1;
          if (!cell_q && empty && last_q) begin
            state_q <= ST_FLUSH;
            tmr_q   <= '0;
          end
        end
        ST_FLUSH: if (!cell_q) begin
          // completion wins over timeout at the same boundary
          if (tgt_done_i) begin
            state_q <= ST_TRAIL;
            tmr_q   <= '0;
          end else if (tmr_q == TO_LIM) begin
            state_q <= ST_IDLE;
            err_q   <= 1'b1;
          end else begin
            cell_q <= 1'b1;
            tmr_q  <= tmr_q + 1'b1;
          end
        end
        ST_TRAIL: if (!cell_q) begin
          if (tmr_q == TR_LIM) begin
            state_q <= ST_IDLE;
            ok_q    <= 1'b1;
          end else begin
            cell_q <= 1'b1;
            tmr_q  <= tmr_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/slave_cfg_loader_chk.sv
module slave_cfg_loader_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic ready_o,
  input logic sclk_o,
  input logic mosi_o,
  input logic cs_no,
  input logic tgt_rst_no,
  input logic busy_o,
  input logic done_ok_o,
  input logic error_o
);
  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> (!sclk_o && !busy_o && !ready_o));

  assert_sel_at_release_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tgt_rst_no) |-> !cs_no);

  assert_no_clk_in_reset_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tgt_rst_no |-> (!sclk_o && !cs_no));

  assert_data_stable_high_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_o && $past(sclk_o)) |-> $stable(mosi_o));

  assert_ready_window_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (busy_o && !sclk_o));

  assert_start_ignored_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && tgt_rst_no && start_i) |=> tgt_rst_no);

  assert_flags_exclusive_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_ok_o && error_o));

  assert_flags_clear_busy_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (!done_ok_o && !error_o));
endmodule

bind slave_cfg_loader slave_cfg_loader_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .ready_o   (ready_o),
  .sclk_o    (sclk_o),
  .mosi_o    (mosi_o),
  .cs_no     (cs_no),
  .tgt_rst_no(tgt_rst_no),
  .busy_o    (busy_o),
  .done_ok_o (done_ok_o),
  .error_o   (error_o)
);

// File: tb/slave_cfg_loader_tb.sv
module slave_cfg_loader_tb;
  localparam int CLK_T   = 10;
  localparam int RST_CYC = 3;
  localparam int WAIT_CY = 4;
  localparam int TO_CLKS = 5;
  localparam int TRAIL   = 48;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, valid = 1'b0, last = 1'b0, done_in = 1'b0;
  logic [7:0] byte_d = '0;
  logic ready, sclk, mosi, cs_n, trst_n, busy, ok, err;
  int nchk = 0, nfail = 0;

  always #(CLK_T/2) clk = ~clk;

  slave_cfg_loader #(
    .DATA_W(8), .HALF(2), .RST_CYC(RST_CYC), .WAIT_CYC(WAIT_CY),
    .TIMEOUT_CLKS(TO_CLKS), .TRAIL_CLKS(TRAIL)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .byte_i(byte_d),
    .valid_i(valid), .last_i(last), .ready_o(ready), .sclk_o(sclk),
    .mosi_o(mosi), .cs_no(cs_n), .tgt_rst_no(trst_n), .tgt_done_i(done_in),
    .busy_o(busy), .done_ok_o(ok), .error_o(err)
  );

  task automatic chk(input bit good, input string req, input int act, input int exp);
    nchk++;
    if (!good) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_job(input int n, input int k, input int gap, input int mid_at, input int seed);
    logic [7:0] tx [0:7];
    logic [7:0] rx [0:7];
    int cyc = 0, rises = 0, flush_r = 0, trail_r = 0, rst_len = 0, pulses = 0;
    int rel_cyc = -1, first_gap = -1, bad_fill = 0, bad_cs = 0, rel_cs = 0;
    int idx = 0, gap_ctr = 0, data_bad = 0;
    bit prev_sclk = 1'b0, prev_rst = 1'b1, done_set = 1'b0, pend = 1'b0;
    for (int i = 0; i < 8; i++) begin
      tx[i] = 8'((seed * 37 + i * 29 + 5) & 255);
      rx[i] = '0;
    end
    done_in = 1'b0; valid = 1'b0; last = 1'b0;
    @(negedge clk);
    start = 1'b1;
    while (cyc < 6000) begin
      @(negedge clk);
      if (cyc == 0) begin
        start = 1'b0;
        chk(busy && !ok && !err, "R10 flags cleared on start", {ok, err}, 0);
      end
      if (mid_at != 0 && cyc == mid_at) start = 1'b1;
      if (mid_at != 0 && cyc == mid_at + 1) start = 1'b0;
      if (cyc > 0 && !busy) break;
      // reset pin
      if (!trst_n) begin
        rst_len++;
        if (prev_rst) pulses++;
        if (cs_n) bad_cs++;
      end else if (!prev_rst) begin
        rel_cyc = cyc;
        if (cs_n) rel_cs++;
      end
      if (sclk && (!trst_n || cs_n)) bad_cs++;
      prev_rst = trst_n;
      // serial clock edges
      if (sclk && !prev_sclk) begin
        rises++;
        if (rises == 1) first_gap = cyc - rel_cyc;
        if (rises <= 8 * n) rx[(rises-1)/8][7-((rises-1)%8)] = mosi;
        else begin
          if (!mosi) bad_fill++;
          if (done_set) trail_r++; else flush_r++;
        end
        if (!done_set && k >= 0 && rises == 8 * n + k) begin
          done_set = 1'b1;
          done_in  = 1'b1;
        end
      end
      prev_sclk = sclk;
      // byte handshake
      if (pend) begin
        idx++;
        gap_ctr = gap;
        valid = 1'b0;
      end
      if (!valid && idx < n) begin
        if (gap_ctr > 0) gap_ctr--;
        else begin
          valid = 1'b1; byte_d = tx[idx]; last = (idx == n - 1);
        end
      end
      pend = valid && ready;
      cyc++;
    end
    valid = 1'b0;
    chk(cyc < 6000, "R7 run ends", cyc, 6000);
    chk(rst_len == RST_CYC, "R2 reset width", rst_len, RST_CYC);
    chk(pulses == 1, mid_at != 0 ? "R9 single reset pulse" : "R2 single reset pulse", pulses, 1);
    chk(bad_cs == 0 && rel_cs == 0, "R2 select low at release", bad_cs + rel_cs, 0);
    chk(first_gap >= WAIT_CY, "R3 wait before first clock", first_gap, WAIT_CY);
    for (int i = 0; i < n; i++) if (rx[i] != tx[i]) data_bad++;
    chk(data_bad == 0 && idx == n, "R4 R5 bytes msb first", data_bad, 0);
    chk(bad_fill == 0, "R6 fill bits high", bad_fill, 0);
    if (k >= 0) begin
      chk(flush_r == k, "R6 post-stream cells", flush_r, k);
      chk(trail_r == TRAIL, "R7 trailing clocks", trail_r, TRAIL);
      chk(ok && !err, "R7 success flag", {ok, err}, 2);
    end else begin
      chk(flush_r == TO_CLKS, "R8 cells before timeout", flush_r, TO_CLKS);
      chk(trail_r == 0, "R8 no trailing clocks", trail_r, 0);
      chk(err && !ok, "R8 error flag", {ok, err}, 1);
    end
    done_in = 1'b0;
    repeat (3) @(negedge clk);
    chk(ok == (k >= 0) && err == (k < 0), "R10 flags hold", {ok, err}, k >= 0 ? 2 : 1);
    chk(cs_n && trst_n && !sclk && !busy, "R7 pins idle after run", {cs_n, trst_n, sclk, busy}, 12);
  endtask

  initial begin
    #(CLK_T * 150000);
    nfail++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(cs_n && trst_n && !sclk && !ready && !busy && !ok && !err, "R1 reset state",
        {cs_n, trst_n, sclk, ready, busy, ok, err}, 96);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cs_n && trst_n && !sclk && !busy, "R1 idle after reset", {cs_n, trst_n, sclk, busy}, 12);
    for (int n = 1; n <= 3; n++)
      for (int k = -1; k <= TO_CLKS; k++)
        run_job(n, k, (n + k + 3) % 3, (k == 1) ? 2 : ((k == 3) ? 30 : 0), n * 7 + k + 1);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule